// File: doc/BRIEF.md
# Dual-Port Byte Memory with Semaphore Flags

This block is a clocked memory with two independent access ports, left and right, that share one byte-wide array. It also holds a small bank of hardware semaphore flags that the two sides use to agree on which one owns a shared resource. Each port has a two-input chip select, a read/write line, an active-low output enable and an active-low semaphore select. A decoder for each port turns these inputs into one access mode for that cycle. Read data, the valid marker and the error marker are all registered, so they appear one clock after the request.

Each semaphore flag is either free or held by one port. A port asks for a flag by writing 0 to it and releases the flag by writing 1. Reading a flag gives 0 to the port that holds it and 1 to everyone else. A request that cannot be granted at once is remembered, and it is granted as soon as the holder lets go. When both ports ask for the same free flag in the same cycle, the left port gets it.

Top module: `dual_port_sem_ram`

## Requirements
- R1: A port is selected only when its first chip enable is 0 and its second chip enable is 1. With semaphore select at 1, a port that is not selected writes nothing and its valid output is 0 in the next cycle.
- R2: A selected port with semaphore select 1 and read/write 0 writes its data input to the shared array at its address. This happens whatever the output enable is, and the valid output is 0 in the next cycle.
- R3: A selected port with semaphore select 1, read/write 1 and output enable 0 shows the stored byte on its data output in the next cycle, with valid 1. Both ports read the same shared array.
- R4: When output enable is 1, valid is 0 in the next cycle whatever the other inputs are. Whenever valid is 0 the data output is all zeros.
- R5: There are eight flags, and the flag is chosen by the three lowest address bits. A flag read happens when semaphore select is 0, the port is not selected, read/write is 1 and output enable is 0. In the next cycle every data output bit equals the flag value, and valid is 1.
- R6: A flag write happens when semaphore select is 0, the port is not selected and read/write is 0. Only data input bit 0 is used: 0 is a request and 1 is a release.
- R7: Semaphore select 0 together with a selected port is illegal. It changes neither the array nor any flag, valid is 0 in the next cycle, and that port's error output is 1 in the next cycle. The other port's error output stays 0.
- R8: A free flag reads 1 on both ports. A request on a free flag makes it held by the requester, which then reads 0 while the other port reads 1. A release by the holder frees the flag.
- R9: When both ports request the same free flag in the same cycle, the left port becomes the holder.
- R10: A request on a flag held by the other port is kept pending. When the holder releases the flag, it passes straight to the waiting port.
- R11: When both ports write the same array address in the same cycle, the left port's byte is stored.
- R12: Reset frees all flags and drives valid, error and data outputs to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| lCe0N | input | 1 | Left chip enable, active low |
| lCe1 | input | 1 | Left chip enable, active high |
| lRdWr | input | 1 | Left direction, 1 read, 0 write |
| lOeN | input | 1 | Left output enable, active low |
| lSemN | input | 1 | Left semaphore select, active low |
| lAddr | input | ADDR_W | Left address (low three bits pick the flag) |
| lDin | input | DATA_W | Left write data |
| lDout | output | DATA_W | Left read data, zero when not valid |
| lDoutValid | output | 1 | Left read data valid |
| lErr | output | 1 | Left illegal-combination flag |
| rCe0N | input | 1 | Right chip enable, active low |
| rCe1 | input | 1 | Right chip enable, active high |
| rRdWr | input | 1 | Right direction, 1 read, 0 write |
| rOeN | input | 1 | Right output enable, active low |
| rSemN | input | 1 | Right semaphore select, active low |
| rAddr | input | ADDR_W | Right address (low three bits pick the flag) |
| rDin | input | DATA_W | Right write data |
| rDout | output | DATA_W | Right read data, zero when not valid |
| rDoutValid | output | 1 | Right read data valid |
| rErr | output | 1 | Right illegal-combination flag |

## Verification
The control inputs are tried in every decoded mode, plus the two half-selected chip-enable patterns. This separates a correct select decode from one that looks at only one enable, and shows that output enable affects reads but not writes. For the flags, the bench runs a simultaneous request, a release with a waiting requester, and a release in the same cycle as a fresh request. It also sends write data whose upper bits contradict bit 0, and an address whose upper bits differ but whose low three bits match. Together these separate left priority, pending grant, bit-0-only decoding and three-bit flag selection. A same-address double write and an illegal access followed by a read-back show which data the array holds.

// File: rtl/dpsem_pkg.sv
package dpsem_pkg;

  typedef enum logic [2:0] {
    MODE_IDLE,
    MODE_MEM_WR,
    MODE_MEM_RD,
    MODE_OUT_OFF,
    MODE_SEM_RD,
    MODE_SEM_WR,
    MODE_BAD
  } portMode_e;

  typedef struct packed {
    logic memWr;
    logic memRd;
    logic semWr;
    logic semRd;
    logic bad;
  } portStb_t;

endpackage

// File: rtl/dpsem_port_ctrl.sv
module dpsem_port_ctrl
  import dpsem_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     ce0N,
  input  logic     ce1,
  input  logic     rdWr,
  input  logic     oeN,
  input  logic     semN,
  output portStb_t stb,
  output logic     errFlag
);

  logic      portSel;
  logic      semOn;
  portMode_e mode;

  assign portSel = !ce0N && ce1;
  assign semOn   = !semN;

  always_comb begin
    if (semOn && portSel)   mode = MODE_BAD;
    else if (semOn) begin
      if (!rdWr)            mode = MODE_SEM_WR;
      else if (!oeN)        mode = MODE_SEM_RD;
      else                  mode = MODE_OUT_OFF;
    end
    else if (!portSel)      mode = MODE_IDLE;
    else if (!rdWr)         mode = MODE_MEM_WR;
    else if (!oeN)          mode = MODE_MEM_RD;
    else                    mode = MODE_OUT_OFF;
  end

  always_comb begin
    stb.memWr = (mode == MODE_MEM_WR);
    stb.memRd = (mode == MODE_MEM_RD);
    stb.semWr = (mode == MODE_SEM_WR);
    stb.semRd = (mode == MODE_SEM_RD);
    stb.bad   = (mode == MODE_BAD);
  end

  always_ff @(posedge clk) begin
    if (!rstN) errFlag <= 1'b0;
    else       errFlag <= stb.bad;
  end

  AST_ERR_CAUSE: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && errFlag) |-> $past(!semN && !ce0N && ce1)); // R7

  AST_BAD_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (!semN && !ce0N && ce1) |-> !(stb.memWr || stb.semWr)); // R7

endmodule

// File: rtl/dpsem_flag_bank.sv
module dpsem_flag_bank #(
  parameter int NUM_SEM = 8,
  localparam int IDX_W  = $clog2(NUM_SEM)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               lWr,
  input  logic [IDX_W-1:0]   lIdx,
  input  logic               lBit,
  input  logic               rWr,
  input  logic [IDX_W-1:0]   rIdx,
  input  logic               rBit,
  output logic [NUM_SEM-1:0] lView,
  output logic [NUM_SEM-1:0] rView
);

  for (genvar i = 0; i < NUM_SEM; i++) begin : gFlag
    logic busy, own, pendL, pendR;
    logic nBusy, nOwn, nPendL, nPendR;
    logic lHit, rHit, lReq, rReq, lRel, rRel;

    assign lHit = lWr && (lIdx == IDX_W'(i));
    assign rHit = rWr && (rIdx == IDX_W'(i));
    assign lReq = lHit && !lBit;
    assign lRel = lHit && lBit;
    assign rReq = rHit && !rBit;
    assign rRel = rHit && rBit;

    always_comb begin
      nBusy  = busy;
      nOwn   = own;
      nPendL = pendL;
      nPendR = pendR;
      if (!busy) begin
        if (lReq) begin
          nBusy  = 1'b1;
          nOwn   = 1'b0;
          nPendR = rReq;
        end else if (rReq) begin
          nBusy = 1'b1;
          nOwn  = 1'b1;
        end
      end else if (!own) begin
        if (rReq) nPendR = 1'b1;
        if (rRel) nPendR = 1'b0;
        if (lRel) begin
          if (nPendR) begin
            nOwn   = 1'b1;
            nPendR = 1'b0;
          end else begin
            nBusy = 1'b0;
          end
        end
      end else begin
        if (lReq) nPendL = 1'b1;
        if (lRel) nPendL = 1'b0;
        if (rRel) begin
          if (nPendL) begin
            nOwn   = 1'b0;
            nPendL = 1'b0;
          end else begin
            nBusy = 1'b0;
          end
        end
      end
    end

    always_ff @(posedge clk) begin
      if (!rstN) begin
        busy  <= 1'b0;
        own   <= 1'b0;
        pendL <= 1'b0;
        pendR <= 1'b0;
      end else begin
        busy  <= nBusy;
        own   <= nOwn;
        pendL <= nPendL;
        pendR <= nPendR;
      end
    end

    assign lView[i] = !(busy && !own);
    assign rView[i] = !(busy && own);

    AST_LEFT_WINS: assert property (@(posedge clk) disable iff (!rstN)
      (lReq && rReq && !busy) |=> (busy && !own)); // R9

    AST_PEND_LEFT: assert property (@(posedge clk) disable iff (!rstN)
      pendL |-> (busy && own)); // R10

    AST_PEND_RIGHT: assert property (@(posedge clk) disable iff (!rstN)
      pendR |-> (busy && !own)); // R10

    AST_RELEASE_FREES: assert property (@(posedge clk) disable iff (!rstN)
      (busy && !own && lRel && !rReq && !pendR) |=> !busy); // R8
  end

endmodule

// File: rtl/dpsem_datapath.sv
module dpsem_datapath
  import dpsem_pkg::*;
#(
  parameter int DEPTH   = 256,
  parameter int DATA_W  = 8,
  parameter int NUM_SEM = 8,
  localparam int ADDR_W = $clog2(DEPTH),
  localparam int IDX_W  = $clog2(NUM_SEM)
) (
  input  logic              clk,
  input  logic              rstN,
  input  portStb_t          lStb,
  input  portStb_t          rStb,
  input  logic [ADDR_W-1:0] lAddr,
  input  logic [ADDR_W-1:0] rAddr,
  input  logic [DATA_W-1:0] lDin,
  input  logic [DATA_W-1:0] rDin,
  output logic [DATA_W-1:0] lDout,
  output logic              lValid,
  output logic [DATA_W-1:0] rDout,
  output logic              rValid
);

  logic [DATA_W-1:0] memArray [DEPTH];
  logic [NUM_SEM-1:0] lView, rView;

  portStb_t          stbP   [2];
  logic [ADDR_W-1:0] addrP  [2];
  logic [NUM_SEM-1:0] viewP [2];
  logic [DATA_W-1:0] doutQ  [2];
  logic              validQ [2];

  assign stbP[0]  = lStb;
  assign stbP[1]  = rStb;
  assign addrP[0] = lAddr;
  assign addrP[1] = rAddr;
  assign viewP[0] = lView;
  assign viewP[1] = rView;

  dpsem_flag_bank #(.NUM_SEM(NUM_SEM)) uFlags (
    .clk   (clk),
    .rstN  (rstN),
    .lWr   (lStb.semWr),
    .lIdx  (lAddr[IDX_W-1:0]),
    .lBit  (lDin[0]),
    .rWr   (rStb.semWr),
    .rIdx  (rAddr[IDX_W-1:0]),
    .rBit  (rDin[0]),
    .lView (lView),
    .rView (rView)
  );

  // Right first so the left write takes effect on an address clash.
  always_ff @(posedge clk) begin
    if (rStb.memWr) memArray[rAddr] <= rDin;
    if (lStb.memWr) memArray[lAddr] <= lDin;
  end

  for (genvar p = 0; p < 2; p++) begin : gRead
    always_ff @(posedge clk) begin
      if (!rstN) begin
        doutQ[p]  <= '0;
        validQ[p] <= 1'b0;
      end else begin
        validQ[p] <= stbP[p].memRd || stbP[p].semRd;
        if (stbP[p].memRd)
          doutQ[p] <= memArray[addrP[p]];
        else if (stbP[p].semRd)
          doutQ[p] <= {DATA_W{viewP[p][addrP[p][IDX_W-1:0]]}};
        else
          doutQ[p] <= '0;
      end
    end

    AST_VALID_FROM_READ: assert property (@(posedge clk) disable iff (!rstN)
      ($past(rstN) && validQ[p]) |-> $past(stbP[p].memRd || stbP[p].semRd)); // R3

    AST_SEM_BYTE: assert property (@(posedge clk) disable iff (!rstN)
      ($past(rstN) && $past(stbP[p].semRd)) |->
        (doutQ[p] == '0 || doutQ[p] == '1)); // R5
  end

  assign lDout  = doutQ[0];
  assign lValid = validQ[0];
  assign rDout  = doutQ[1];
  assign rValid = validQ[1];

endmodule

// File: rtl/dual_port_sem_ram.sv
module dual_port_sem_ram
  import dpsem_pkg::*;
#(
  parameter int DEPTH   = 256,
  parameter int DATA_W  = 8,
  parameter int NUM_SEM = 8,
  localparam int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              lCe0N,
  input  logic              lCe1,
  input  logic              lRdWr,
  input  logic              lOeN,
  input  logic              lSemN,
  input  logic [ADDR_W-1:0] lAddr,
  input  logic [DATA_W-1:0] lDin,
  output logic [DATA_W-1:0] lDout,
  output logic              lDoutValid,
  output logic              lErr,
  input  logic              rCe0N,
  input  logic              rCe1,
  input  logic              rRdWr,
  input  logic              rOeN,
  input  logic              rSemN,
  input  logic [ADDR_W-1:0] rAddr,
  input  logic [DATA_W-1:0] rDin,
  output logic [DATA_W-1:0] rDout,
  output logic              rDoutValid,
  output logic              rErr
);

  localparam int IDX_W = $clog2(NUM_SEM);

  portStb_t lStb, rStb;

  dpsem_port_ctrl uLeftCtrl (
    .clk (clk), .rstN (rstN),
    .ce0N (lCe0N), .ce1 (lCe1), .rdWr (lRdWr), .oeN (lOeN), .semN (lSemN),
    .stb (lStb), .errFlag (lErr)
  );

  dpsem_port_ctrl uRightCtrl (
    .clk (clk), .rstN (rstN),
    .ce0N (rCe0N), .ce1 (rCe1), .rdWr (rRdWr), .oeN (rOeN), .semN (rSemN),
    .stb (rStb), .errFlag (rErr)
  );

  dpsem_datapath #(.DEPTH(DEPTH), .DATA_W(DATA_W), .NUM_SEM(NUM_SEM)) uData (
    .clk    (clk),
    .rstN   (rstN),
    .lStb   (lStb),
    .rStb   (rStb),
    .lAddr  (lAddr),
    .rAddr  (rAddr),
    .lDin   (lDin),
    .rDin   (rDin),
    .lDout  (lDout),
    .lValid (lDoutValid),
    .rDout  (rDout),
    .rValid (rDoutValid)
  );

  AST_OE_QUIET_L: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(lOeN)) |-> !lDoutValid); // R4

  AST_OE_QUIET_R: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(rOeN)) |-> !rDoutValid); // R4

  AST_ZERO_WHEN_INVALID: assert property (@(posedge clk) disable iff (!rstN)
    (!lDoutValid |-> lDout == '0) and (!rDoutValid |-> rDout == '0)); // R4

  AST_SEM_MUTEX: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(lStb.semRd && rStb.semRd &&
      lAddr[IDX_W-1:0] == rAddr[IDX_W-1:0]))
      |-> !(lDout == '0 && rDout == '0)); // R8

endmodule

// File: tb/dual_port_sem_ram_test.sv
module dual_port_sem_ram_test;

  // control field order: {ce0N, ce1, rdWr, oeN, semN}
  localparam logic [4:0] C_IDLE = 5'b10111;
  localparam logic [4:0] C_WR   = 5'b01011;
  localparam logic [4:0] C_WROE = 5'b01001;
  localparam logic [4:0] C_RD   = 5'b01101;
  localparam logic [4:0] C_OFF  = 5'b01111;
  localparam logic [4:0] C_DSW  = 5'b11011; // both enables high: not selected
  localparam logic [4:0] C_DSR  = 5'b00101; // both enables low: not selected
  localparam logic [4:0] C_SRD  = 5'b10100;
  localparam logic [4:0] C_SOFF = 5'b10110;
  localparam logic [4:0] C_SWR  = 5'b10010;
  localparam logic [4:0] C_ILL  = 5'b01010;
  localparam logic [4:0] C_ILLR = 5'b01100;

  typedef struct packed {
    logic [4:0] lc; logic [7:0] la; logic [7:0] ld;
    logic [4:0] rc; logic [7:0] ra; logic [7:0] rd;
    logic [7:0] eLd; logic eLv; logic eLe;
    logic [7:0] eRd; logic eRv; logic eRe;
    logic [3:0] req;
  } vec_t;

  localparam int NV = 21;
  localparam vec_t VECS [NV] = '{
    '{C_WR,   8'h10, 8'hA5, C_IDLE, 8'h00, 8'h00, 8'h00,1'b0,1'b0, 8'h00,1'b0,1'b0, 4'd2},  // R2
    '{C_RD,   8'h10, 8'h00, C_WROE, 8'h20, 8'h3C, 8'hA5,1'b1,1'b0, 8'h00,1'b0,1'b0, 4'd3},  // R3 R2
    '{C_IDLE, 8'h00, 8'h00, C_RD,   8'h20, 8'h00, 8'h00,1'b0,1'b0, 8'h3C,1'b1,1'b0, 4'd2},  // R2
    '{C_OFF,  8'h10, 8'h00, C_RD,   8'h10, 8'h00, 8'h00,1'b0,1'b0, 8'hA5,1'b1,1'b0, 4'd4},  // R4 R3
    '{C_DSW,  8'h10, 8'hFF, C_DSR,  8'h10, 8'h00, 8'h00,1'b0,1'b0, 8'h00,1'b0,1'b0, 4'd1},  // R1
    '{C_RD,   8'h10, 8'h00, C_IDLE, 8'h00, 8'h00, 8'hA5,1'b1,1'b0, 8'h00,1'b0,1'b0, 4'd1},  // R1
    '{C_WR,   8'h30, 8'h11, C_WR,   8'h30, 8'h22, 8'h00,1'b0,1'b0, 8'h00,1'b0,1'b0, 4'd11}, // R11
    '{C_RD,   8'h30, 8'h00, C_RD,   8'h30, 8'h00, 8'h11,1'b1,1'b0, 8'h11,1'b1,1'b0, 4'd11}, // R11
    '{C_ILL,  8'h30, 8'h99, C_IDLE, 8'h00, 8'h00, 8'h00,1'b0,1'b1, 8'h00,1'b0,1'b0, 4'd7},  // R7
    '{C_RD,   8'h30, 8'h00, C_SRD,  8'h03, 8'h00, 8'h11,1'b1,1'b0, 8'hFF,1'b1,1'b0, 4'd8},  // R7 R8
    '{C_SWR,  8'h03, 8'hFE, C_SWR,  8'h03, 8'h00, 8'h00,1'b0,1'b0, 8'h00,1'b0,1'b0, 4'd9},  // R9
    '{C_SRD,  8'h03, 8'h00, C_SRD,  8'h03, 8'h00, 8'h00,1'b1,1'b0, 8'hFF,1'b1,1'b0, 4'd9},  // R9
    '{C_SWR,  8'h03, 8'h81, C_IDLE, 8'h00, 8'h00, 8'h00,1'b0,1'b0, 8'h00,1'b0,1'b0, 4'd6},  // R6
    '{C_SRD,  8'h03, 8'h00, C_SRD,  8'h03, 8'h00, 8'hFF,1'b1,1'b0, 8'h00,1'b1,1'b0, 4'd10}, // R10
    '{C_SWR,  8'h0B, 8'hFE, C_SWR,  8'h03, 8'hFF, 8'h00,1'b0,1'b0, 8'h00,1'b0,1'b0, 4'd6},  // R6 R10
    '{C_SRD,  8'h03, 8'h00, C_SRD,  8'h13, 8'h00, 8'h00,1'b1,1'b0, 8'hFF,1'b1,1'b0, 4'd5},  // R5
    '{C_SRD,  8'h04, 8'h00, C_SRD,  8'h03, 8'h00, 8'hFF,1'b1,1'b0, 8'hFF,1'b1,1'b0, 4'd5},  // R5
    '{C_SWR,  8'h03, 8'h01, C_SWR,  8'h04, 8'h00, 8'h00,1'b0,1'b0, 8'h00,1'b0,1'b0, 4'd8},  // R8
    '{C_SRD,  8'h04, 8'h00, C_SRD,  8'h04, 8'h00, 8'hFF,1'b1,1'b0, 8'h00,1'b1,1'b0, 4'd8},  // R8
    '{C_SOFF, 8'h03, 8'h00, C_SRD,  8'h03, 8'h00, 8'h00,1'b0,1'b0, 8'hFF,1'b1,1'b0, 4'd4},  // R4 R8
    '{C_ILLR, 8'h10, 8'h00, C_IDLE, 8'h00, 8'h00, 8'h00,1'b0,1'b1, 8'h00,1'b0,1'b0, 4'd7}   // R7
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic lCe0N, lCe1, lRdWr, lOeN, lSemN;
  logic rCe0N, rCe1, rRdWr, rOeN, rSemN;
  logic [7:0] lAddr, lDin, rAddr, rDin;
  logic [7:0] lDout, rDout;
  logic lDoutValid, rDoutValid, lErr, rErr;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  dual_port_sem_ram uut (
    .clk (clk), .rstN (rstN),
    .lCe0N (lCe0N), .lCe1 (lCe1), .lRdWr (lRdWr), .lOeN (lOeN), .lSemN (lSemN),
    .lAddr (lAddr), .lDin (lDin), .lDout (lDout), .lDoutValid (lDoutValid), .lErr (lErr),
    .rCe0N (rCe0N), .rCe1 (rCe1), .rRdWr (rRdWr), .rOeN (rOeN), .rSemN (rSemN),
    .rAddr (rAddr), .rDin (rDin), .rDout (rDout), .rDoutValid (rDoutValid), .rErr (rErr)
  );

  task automatic drive(input logic [4:0] lc, input logic [7:0] la, input logic [7:0] ld,
                       input logic [4:0] rc, input logic [7:0] ra, input logic [7:0] rd);
    {lCe0N, lCe1, lRdWr, lOeN, lSemN} = lc;
    {rCe0N, rCe1, rRdWr, rOeN, rSemN} = rc;
    lAddr = la; lDin = ld; rAddr = ra; rDin = rd;
  endtask

  task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic chkAll(input string tag, input vec_t v);
    chk({tag, " left data"},   lDout, v.eLd);
    chk({tag, " left valid"},  {7'd0, lDoutValid}, {7'd0, v.eLv});
    chk({tag, " left err"},    {7'd0, lErr}, {7'd0, v.eLe});
    chk({tag, " right data"},  rDout, v.eRd);
    chk({tag, " right valid"}, {7'd0, rDoutValid}, {7'd0, v.eRv});
    chk({tag, " right err"},   {7'd0, rErr}, {7'd0, v.eRe});
  endtask

  initial begin
    drive(C_IDLE, 8'h00, 8'h00, C_IDLE, 8'h00, 8'h00);
    repeat (3) @(negedge clk);
    // R12: outputs cleared under reset
    chkAll("R12 reset", '{C_IDLE,8'h00,8'h00,C_IDLE,8'h00,8'h00,
                          8'h00,1'b0,1'b0,8'h00,1'b0,1'b0,4'd12});
    rstN = 1'b1;

    for (int i = 0; i < NV; i++) begin
      drive(VECS[i].lc, VECS[i].la, VECS[i].ld, VECS[i].rc, VECS[i].ra, VECS[i].rd);
      @(negedge clk);
      chkAll($sformatf("R%0d row %0d", VECS[i].req, i), VECS[i]);
    end

    // R12: reset releases flag 4 held by the right port
    drive(C_IDLE, 8'h00, 8'h00, C_IDLE, 8'h00, 8'h00);
    rstN = 1'b0;
    @(negedge clk);
    rstN = 1'b1;
    drive(C_SRD, 8'h04, 8'h00, C_SRD, 8'h04, 8'h00);
    @(negedge clk);
    chkAll("R12 flags freed", '{C_SRD,8'h04,8'h00,C_SRD,8'h04,8'h00,
                                8'hFF,1'b1,1'b0,8'hFF,1'b1,1'b0,4'd12});

    // R7: right-side illegal access flags only the right port and writes nothing
    drive(C_IDLE, 8'h00, 8'h00, C_ILL, 8'h20, 8'h77);
    @(negedge clk);
    chkAll("R7 right illegal", '{C_IDLE,8'h00,8'h00,C_ILL,8'h20,8'h77,
                                 8'h00,1'b0,1'b0,8'h00,1'b0,1'b1,4'd7});
    drive(C_IDLE, 8'h00, 8'h00, C_RD, 8'h20, 8'h00);
    @(negedge clk);
    chkAll("R7 array intact", '{C_IDLE,8'h00,8'h00,C_RD,8'h20,8'h00,
                                8'h00,1'b0,1'b0,8'h3C,1'b1,1'b0,4'd7});

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule